// File: doc/BRIEF.md
# Real-Mode Interrupt Entry and Return Sequencer

This block is the control unit that takes a simple 16-bit real-mode processor into and out of an interrupt handler. At every instruction boundary the core offers its architectural state (flags, code segment, instruction pointer, stack segment, stack pointer). The block then decides whether an interrupt is due. It picks one source by fixed priority: a latched non-maskable request first, then the level-sensitive maskable request if the interrupt-enable flag is set, then the single-step trap. For a maskable request it pulses an acknowledge output and takes the 8-bit vector type from the data lines during that pulse.

Once a source is taken, the block drives a single-cycle word memory port. It pushes the flags, then clears the interrupt-enable and trap flags. It then pushes the code segment and the instruction pointer, and reads the 4-byte vector at byte address type×4. The low word of the vector gives the new instruction pointer and the high word gives the new code segment. A return request runs the opposite walk. It pops the instruction pointer, the code segment and the flags from the stack and hands the restored state back. In both cases the updated state is offered for one cycle on `done`, and the core loads it before its next fetch.

Top module: `irq_entry_seq`

## Requirements
- R1: During and directly after reset, `busy`, `done`, `inta` and `mem_req` are all 0.
- R2: When `boundary` is high and the block is idle, at most one source is taken. The order is: a pending NMI, then `intr` with IF set, then the trap with TF set. With none of these, the block stays idle and issues no memory access.
- R3: `intr` is level-sensitive and is taken only while IF (flags bit 9) is 1. After an entry, IF stays clear in the returned flags, so a held `intr` is refused until a return restores IF.
- R4: Taking `intr` raises `inta` for exactly one cycle, the cycle after acceptance. `irq_type` is sampled at the end of that cycle, and the flags push follows in the next cycle.
- R5: A rising edge on `nmi` is latched as pending, including while the block is busy. It is taken at the next idle boundary as type 2, whatever the value of IF.
- R6: With TF (flags bit 8) set and no higher request, a boundary takes a type 1 trap.
- R7: An entry writes three words in consecutive cycles: the flags at SS·16+SP−2, then CS at SP−4, then IP at SP−6. These are 20-bit physical byte addresses, and SP is decremented by 2 before each write.
- R8: The flags word pushed is the original value. The returned flags equal it with bits 9 and 8 cleared and all other bits unchanged.
- R9: After the pushes, the block reads byte address 4·n, then 4·n+2, for vector type n. The new IP is the word at 4·n, the new CS is the word at 4·n+2, and the returned SP is the entry SP−6.
- R10: A return request read the words at SS·16+SP, SP+2 and SP+4 in consecutive cycles. They are returned as IP, CS and flags, and the returned SP is SP+6.
- R11: `busy` is high from the cycle after acceptance until the single-cycle `done`, and low after it. `boundary` and `iret_req` are ignored while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction-boundary strobe, evaluated when idle |
| iret_req | input | 1 | Return-from-interrupt request, takes precedence over `boundary` |
| nmi | input | 1 | Non-maskable request, rising-edge latched |
| intr | input | 1 | Maskable request, level-sensitive |
| inta | output | 1 | Acknowledge pulse for a maskable request |
| irq_type | input | 8 | Vector type lines, sampled during `inta` |
| flags_in | input | 16 | Current flags word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | 20 | Physical byte address (even) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle strobe: updated state is valid |
| flags_out | output | 16 | Flags to load on `done` |
| cs_out | output | 16 | Code segment to load on `done` |
| ip_out | output | 16 | Instruction pointer to load on `done` |
| sp_out | output | 16 | Stack pointer to load on `done` |

## Verification
A wrong state step appears on the memory port in the very next cycle. It shows as a missing, reordered or misaddressed push, or as a vector read at the wrong type×4. A working stack pointer that drifts shows up one cycle later as an address off by two. A save register that is corrupted stays hidden until a return: IP, CS or flags then come back wrong on `done`, several cycles after the fault. Arbitration faults show at the boundary cycle itself. They appear as an `inta` pulse where none is due, or as a vector read for the wrong type, or as a refused request that should have been taken.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  parameter int WORD_W  = 16;
  parameter int PADDR_W = 20;
  parameter int TYPE_W  = 8;
  parameter int IF_BIT  = 9;
  parameter int TF_BIT  = 8;
  localparam int SEG_SHIFT = PADDR_W - WORD_W;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [PADDR_W-1:0] paddr_t;
  typedef logic [TYPE_W-1:0]  vtype_t;

  localparam word_t  WSTEP     = word_t'(2);
  localparam vtype_t NMI_TYPE  = vtype_t'(2);
  localparam vtype_t TRAP_TYPE = vtype_t'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_ACK, S_PSH_FL, S_PSH_CS, S_PSH_IP,
    S_VEC_LO, S_VEC_HI, S_VEC_LD,
    S_POP_IP, S_POP_CS, S_POP_FL, S_POP_LD, S_DONE
  } seq_state_e;

  // segment:offset to physical byte address
  function automatic paddr_t seg_addr(word_t seg, word_t off);
    return {seg, {SEG_SHIFT{1'b0}}} + paddr_t'(off);
  endfunction

  // vector table word address: type*4, +2 for the segment half
  function automatic paddr_t vec_addr(vtype_t t, logic hi);
    return paddr_t'({t, hi, 1'b0});
  endfunction

  function automatic word_t mask_entry_flags(word_t f);
    word_t r;
    r = f;
    r[IF_BIT] = 1'b0;
    r[TF_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/irq_src_arb.sv
module irq_src_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic evaluate,
  input  logic nmi,
  input  logic intr,
  input  logic if_flag,
  input  logic tf_flag,
  output logic take_nmi,
  output logic take_intr,
  output logic take_trap,
  output logic nmi_pend
);
  logic nmi_q;
  logic intr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi;
      nmi_pend <= (nmi_pend & ~take_nmi) | (nmi & ~nmi_q);
    end
  end

  always_comb begin
    intr_ok   = intr & if_flag;
    take_nmi  = evaluate & nmi_pend;
    take_intr = evaluate & ~nmi_pend & intr_ok;
    take_trap = evaluate & ~nmi_pend & ~intr_ok & tf_flag;
  end
endmodule

// File: rtl/irq_mem_port.sv
module irq_mem_port
  import irq_seq_pkg::*;
(
  input  seq_state_e state,
  input  word_t      ss,
  input  word_t      sp,
  input  vtype_t     vtype,
  input  word_t      fl,
  input  word_t      cs,
  input  word_t      ip,
  output logic       req,
  output logic       we,
  output paddr_t     addr,
  output word_t      wdata
);
  word_t sp_dec;

  always_comb begin
    sp_dec = sp - WSTEP;
    req    = 1'b0;
    we     = 1'b0;
    addr   = '0;
    wdata  = '0;
    case (state)
      S_PSH_FL: begin req = 1'b1; we = 1'b1; addr = seg_addr(ss, sp_dec); wdata = fl; end
      S_PSH_CS: begin req = 1'b1; we = 1'b1; addr = seg_addr(ss, sp_dec); wdata = cs; end
      S_PSH_IP: begin req = 1'b1; we = 1'b1; addr = seg_addr(ss, sp_dec); wdata = ip; end
      S_VEC_LO: begin req = 1'b1; addr = vec_addr(vtype, 1'b0); end
      S_VEC_HI: begin req = 1'b1; addr = vec_addr(vtype, 1'b1); end
      S_POP_IP, S_POP_CS, S_POP_FL: begin req = 1'b1; addr = seg_addr(ss, sp); end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boundary,
  input  logic                iret_req,
  input  logic                nmi,
  input  logic                intr,
  output logic                inta,
  input  logic [TYPE_W-1:0]   irq_type,
  input  logic [WORD_W-1:0]   flags_in,
  input  logic [WORD_W-1:0]   cs_in,
  input  logic [WORD_W-1:0]   ip_in,
  input  logic [WORD_W-1:0]   ss_in,
  input  logic [WORD_W-1:0]   sp_in,
  output logic                mem_req,
  output logic                mem_we,
  output logic [PADDR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic [WORD_W-1:0]   flags_out,
  output logic [WORD_W-1:0]   cs_out,
  output logic [WORD_W-1:0]   ip_out,
  output logic [WORD_W-1:0]   sp_out
);
  seq_state_e state;
  word_t  fl_q, cs_q, ip_q, sp_q, ss_q;
  vtype_t type_q;

  // named events for the checker
  logic idle, evaluate, take_nmi, take_intr, take_trap, take_any, nmi_pend, if_now, ret_start;

  assign idle      = (state == S_IDLE);
  assign evaluate  = idle & boundary & ~iret_req;
  assign ret_start = idle & iret_req;
  assign if_now    = flags_in[IF_BIT];
  assign take_any  = take_nmi | take_intr | take_trap;

  irq_src_arb u_arb (
    .clk(clk), .rst_n(rst_n), .evaluate(evaluate), .nmi(nmi), .intr(intr),
    .if_flag(if_now), .tf_flag(flags_in[TF_BIT]),
    .take_nmi(take_nmi), .take_intr(take_intr), .take_trap(take_trap), .nmi_pend(nmi_pend)
  );

  irq_mem_port u_port (
    .state(state), .ss(ss_q), .sp(sp_q), .vtype(type_q),
    .fl(fl_q), .cs(cs_q), .ip(ip_q),
    .req(mem_req), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      fl_q   <= '0;
      cs_q   <= '0;
      ip_q   <= '0;
      sp_q   <= '0;
      ss_q   <= '0;
      type_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ret_start) begin
            sp_q  <= sp_in;
            ss_q  <= ss_in;
            state <= S_POP_IP;
          end else if (take_any) begin
            fl_q   <= flags_in;
            cs_q   <= cs_in;
            ip_q   <= ip_in;
            sp_q   <= sp_in;
            ss_q   <= ss_in;
            type_q <= take_nmi ? NMI_TYPE : TRAP_TYPE;
            state  <= take_intr ? S_ACK : S_PSH_FL;
          end
        end
        S_ACK: begin
          type_q <= irq_type;
          state  <= S_PSH_FL;
        end
        S_PSH_FL: begin
          sp_q  <= sp_q - WSTEP;
          fl_q  <= mask_entry_flags(fl_q);
          state <= S_PSH_CS;
        end
        S_PSH_CS: begin sp_q <= sp_q - WSTEP; state <= S_PSH_IP; end
        S_PSH_IP: begin sp_q <= sp_q - WSTEP; state <= S_VEC_LO; end
        S_VEC_LO: state <= S_VEC_HI;
        S_VEC_HI: begin ip_q <= mem_rdata; state <= S_VEC_LD; end
        S_VEC_LD: begin cs_q <= mem_rdata; state <= S_DONE; end
        S_POP_IP: begin sp_q <= sp_q + WSTEP; state <= S_POP_CS; end
        S_POP_CS: begin ip_q <= mem_rdata; sp_q <= sp_q + WSTEP; state <= S_POP_FL; end
        S_POP_FL: begin cs_q <= mem_rdata; sp_q <= sp_q + WSTEP; state <= S_POP_LD; end
        S_POP_LD: begin fl_q <= mem_rdata; state <= S_DONE; end
        S_DONE:   state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign inta      = (state == S_ACK);
  assign busy      = ~idle;
  assign done      = (state == S_DONE);
  assign flags_out = fl_q;
  assign cs_out    = cs_q;
  assign ip_out    = ip_q;
  assign sp_out    = sp_q;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
  import irq_seq_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input logic         inta,
  input logic         busy,
  input logic         done,
  input logic         mem_req,
  input logic         mem_we,
  input logic [PADDR_W-1:0] mem_addr,
  input logic         evaluate,
  input logic         take_nmi,
  input logic         take_intr,
  input logic         take_trap,
  input logic         nmi_pend,
  input logic         if_now
);
  a_r2_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_nmi, take_intr, take_trap}));

  a_r2_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (evaluate && nmi_pend) |-> take_nmi);

  a_r3_intr_needs_if: assert property (@(posedge clk) disable iff (!rst_n)
    take_intr |-> if_now);

  a_r4_inta_single: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> !inta);

  a_r4_push_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> (mem_req && mem_we));

  a_r7_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == PADDR_W'($past(mem_addr) - PADDR_W'(2))));

  a_r9_vector_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && $past(mem_we)) |-> (mem_addr[PADDR_W-1:TYPE_W+2] == '0));

  a_r11_access_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || inta) |-> busy);

  a_r11_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .evaluate(evaluate), .take_nmi(take_nmi), .take_intr(take_intr),
  .take_trap(take_trap), .nmi_pend(nmi_pend), .if_now(if_now)
);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
  import irq_seq_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic boundary = 0, iret_req = 0, nmi = 0, intr = 0;
  logic [7:0] irq_type = 8'h00;
  logic [15:0] c_fl, c_cs, c_ip, c_ss, c_sp;
  logic inta, mem_req, mem_we, busy, done;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, rdata_q, flags_out, cs_out, ip_out, sp_out;

  irq_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .iret_req(iret_req),
    .nmi(nmi), .intr(intr), .inta(inta), .irq_type(irq_type),
    .flags_in(c_fl), .cs_in(c_cs), .ip_in(c_ip), .ss_in(c_ss), .sp_in(c_sp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(rdata_q), .busy(busy), .done(done),
    .flags_out(flags_out), .cs_out(cs_out), .ip_out(ip_out), .sp_out(sp_out)
  );

  // memory answering the design, and a separate reference image
  logic [15:0] mem [int];
  logic [15:0] rmem [int];
  initial rdata_q = 16'h0;
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[int'(mem_addr >> 1)] = mem_wdata;
      else rdata_q <= mem.exists(int'(mem_addr >> 1)) ? mem[int'(mem_addr >> 1)] : 16'h0;
    end
  end

  function automatic logic [15:0] ref_rd(int byte_addr);
    return rmem.exists(byte_addr / 2) ? rmem[byte_addr / 2] : 16'h0;
  endfunction

  function automatic int phys(logic [15:0] seg, int off);
    return ((int'(seg) * 16) + (off & 16'hFFFF)) & 20'hFFFFF;
  endfunction

  typedef struct {
    bit inta, busy, done, req, we;
    int addr;
    logic [15:0] wd, oip, ocs, osp, ofl;
    string tag;
  } exp_t;
  exp_t q[$];

  int n_run = 0, n_fail = 0;
  bit nmi_m = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic add(bit ia, bit rq, bit w, int a, logic [15:0] wd, string tag);
    exp_t e;
    e.inta = ia; e.busy = 1; e.done = 0; e.req = rq; e.we = w; e.addr = a; e.wd = wd;
    e.oip = 0; e.ocs = 0; e.osp = 0; e.ofl = 0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic add_done(logic [15:0] ip, logic [15:0] cs, logic [15:0] sp, logic [15:0] fl, string tag);
    exp_t e;
    e.inta = 0; e.busy = 1; e.done = 1; e.req = 0; e.we = 0; e.addr = 0; e.wd = 0;
    e.oip = ip; e.ocs = cs; e.osp = sp; e.ofl = fl; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic compare();
    exp_t e;
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.inta = 0; e.busy = 0; e.done = 0; e.req = 0; e.we = 0; e.addr = 0; e.wd = 0;
      e.oip = 0; e.ocs = 0; e.osp = 0; e.ofl = 0; e.tag = "R2 R11 idle";
    end
    chk(e.tag, "inta", inta, e.inta);
    chk(e.tag, "busy", busy, e.busy);
    chk(e.tag, "done", done, e.done);
    chk(e.tag, "mem_req", mem_req, e.req);
    chk(e.tag, "mem_we", mem_we, e.we);
    if (e.req) chk(e.tag, "mem_addr", mem_addr, e.addr);
    if (e.we) chk(e.tag, "mem_wdata", mem_wdata, e.wd);
    if (e.done) begin
      chk(e.tag, "ip_out", ip_out, e.oip);
      chk(e.tag, "cs_out", cs_out, e.ocs);
      chk(e.tag, "sp_out", sp_out, e.osp);
      chk(e.tag, "flags_out", flags_out, e.ofl);
      c_ip = e.oip; c_cs = e.ocs; c_sp = e.osp; c_fl = e.ofl;
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  // R7 R8 R9: pushes, flag masking, vector fetch
  task automatic enq_entry(int n, bit ack);
    int s0;
    s0 = int'(c_sp);
    if (ack) add(1, 0, 0, 0, 16'h0, "R4");
    add(0, 1, 1, phys(c_ss, s0 - 2), c_fl, "R7 flags");
    rmem[phys(c_ss, s0 - 2) / 2] = c_fl;
    add(0, 1, 1, phys(c_ss, s0 - 4), c_cs, "R7 cs");
    rmem[phys(c_ss, s0 - 4) / 2] = c_cs;
    add(0, 1, 1, phys(c_ss, s0 - 6), c_ip, "R7 ip");
    rmem[phys(c_ss, s0 - 6) / 2] = c_ip;
    add(0, 1, 0, n * 4, 16'h0, "R9 lo");
    add(0, 1, 0, n * 4 + 2, 16'h0, "R9 hi");
    add(0, 0, 0, 0, 16'h0, "R9 wait");
    add_done(ref_rd(n * 4), ref_rd(n * 4 + 2), 16'((s0 - 6) & 16'hFFFF),
             c_fl & 16'hFCFF, "R8 R9 result");
  endtask

  // R10: return walk
  task automatic enq_ret();
    int s0;
    s0 = int'(c_sp);
    add(0, 1, 0, phys(c_ss, s0), 16'h0, "R10 ip");
    add(0, 1, 0, phys(c_ss, s0 + 2), 16'h0, "R10 cs");
    add(0, 1, 0, phys(c_ss, s0 + 4), 16'h0, "R10 flags");
    add(0, 0, 0, 0, 16'h0, "R10 wait");
    add_done(ref_rd(phys(c_ss, s0)), ref_rd(phys(c_ss, s0 + 2)),
             16'((s0 + 6) & 16'hFFFF), ref_rd(phys(c_ss, s0 + 4)), "R10 result");
  endtask

  task automatic drain();
    while (q.size() > 0) step();
    step();
    step();
  endtask

  task automatic do_boundary();
    if (nmi_m) begin enq_entry(2, 0); nmi_m = 0; end            // R5
    else if (intr && c_fl[9]) enq_entry(int'(irq_type), 1);      // R3
    else if (c_fl[8]) enq_entry(1, 0);                           // R6
    boundary = 1;
    step();
    boundary = 0;
    drain();
  endtask

  task automatic do_ret();
    enq_ret();
    iret_req = 1;
    step();
    iret_req = 0;
    drain();
  endtask

  task automatic pulse_nmi();
    nmi = 1;
    step();
    nmi = 0;
    nmi_m = 1;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R11: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int n = 0; n < 256; n++) begin
      mem[2*n]      = 16'h4000 + 16'(n);
      mem[2*n + 1]  = 16'hC000 ^ 16'(n << 4);
      rmem[2*n]     = mem[2*n];
      rmem[2*n + 1] = mem[2*n + 1];
    end
    c_fl = 16'h0002; c_cs = 16'h1234; c_ip = 16'h0100; c_ss = 16'h2000; c_sp = 16'h0200;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "inta", inta, 0);
    chk("R1", "mem_req", mem_req, 0);
    chk("R1", "done", done, 0);
    rst_n = 1;
    step();
    chk("R1", "busy after reset", busy, 0);

    do_boundary();                        // R2: nothing requested
    intr = 1; irq_type = 8'h21;
    do_boundary();                        // R3: IF clear, intr refused
    c_fl = 16'h0202;
    do_boundary();                        // R3 R4: intr taken, type 0x21
    do_boundary();                        // R3: IF now clear, held intr refused
    do_ret();                             // R10: flags restored with IF
    do_boundary();                        // R3: taken again
    do_ret();
    intr = 0;

    c_fl = 16'h0102;
    do_boundary();                        // R6: trap type 1
    do_boundary();                        // R6 R8: TF cleared, no retrap
    do_ret();
    intr = 0;

    c_fl = 16'h0002;
    pulse_nmi();
    do_boundary();                        // R5: type 2 with IF clear
    do_ret();

    c_fl = 16'h0302; intr = 1; irq_type = 8'h40;
    pulse_nmi();
    do_boundary();                        // R2: NMI beats intr and trap
    do_ret();
    do_boundary();                        // R2: intr beats trap
    do_ret();
    intr = 0;
    do_boundary();                        // R2 R6: trap alone
    do_ret();

    // R11 R5 R9: top vector, NMI and strobes during busy
    c_fl = 16'h0202; intr = 1; irq_type = 8'hFF;
    enq_entry(255, 1);
    boundary = 1; step(); boundary = 0;
    step();
    nmi = 1; step(); nmi = 0; nmi_m = 1;
    boundary = 1; step(); boundary = 0;   // R11: ignored while busy
    iret_req = 1; step(); iret_req = 0;   // R11: ignored while busy
    drain();
    intr = 0;
    do_boundary();                        // R5: pending NMI taken afterwards
    do_ret();
    do_ret();

    c_fl = 16'h0202; intr = 1; irq_type = 8'h00;
    do_boundary();                        // R9: type 0 reads bytes 0 and 2
    intr = 0;
    do_ret();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule